// File: doc/BRIEF.md
# Stack and Locals Register Bank

This block is the single register file behind a stack-oriented execution pipeline. It holds the operand stack and the local variable pool of the running method in one 32-entry array. Two pointers give every access its base. The stack pointer counts the occupied stack entries, and the locals base marks the first local variable slot.

Two operand-fetch read ports each choose a base. A stack read counts down from the top of the stack. A locals read counts up from the locals base. One write-back port moves the stack pointer by the pop and push counts of the retiring instruction, and stores its result on the new top of stack or into a local slot. A result that is still being written back is forwarded straight to any read port that asks for that entry. A result that the pipeline marks as already consumed through forwarding is never stored, which saves array writes.

A move that would take the stack pointer out of range is refused and flagged. The locals base is loaded by the method-entry logic; building the rest of the frame is done elsewhere.

Top module: `sl_bank`

## Requirements
- R1: After reset the stack pointer is 0, the locals base is 0, the fault flag is 0 and every entry reads 0.
- R2: On a cycle with `wb_en` high, the stack pointer becomes its old value plus `wb_push` minus `wb_pop`, provided the result lies in 0..32.
- R3: If that result would be below 0 or above 32, the stack pointer and the array are left unchanged and `fault` is 1 in the next cycle only.
- R4: A read port with base 0 (stack) returns the entry at (stack pointer after this cycle's update − 1 − offset) mod 32, so offset 0 is the top of stack.
- R5: A read port with base 1 (locals) returns the entry at (locals base + offset) mod 32.
- R6: With `wb_dst` 0 (stack) and `wb_push` 1, `wb_data` is stored at entry (new stack pointer − 1).
- R7: With `wb_dst` 1 (local), `wb_data` is stored at entry (locals base + `wb_idx`) mod 32, whatever the push and pop counts.
- R8: When a read port addresses the entry written in the same cycle, it returns `wb_data` rather than the stored value.
- R9: A stack push with `wb_fwd` 1 is forwarded in its own cycle but not stored; the entry keeps its previous content.
- R10: `vars_ld` loads `vars_val` into the locals base at the next edge; reads and local stores in that cycle still use the old base.
- R11: With `wb_en` low, neither the stack pointer nor any entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_base | input | 1 | Read port 0 base: 0 stack, 1 locals |
| rd0_off | input | 5 | Read port 0 offset |
| rd1_base | input | 1 | Read port 1 base: 0 stack, 1 locals |
| rd1_off | input | 5 | Read port 1 offset |
| wb_en | input | 1 | Write-back instruction valid |
| wb_dst | input | 1 | Result target: 0 stack top, 1 local slot |
| wb_idx | input | 5 | Local slot index for a local store |
| wb_push | input | 1 | Entries pushed by the instruction |
| wb_pop | input | 2 | Entries popped by the instruction |
| wb_fwd | input | 1 | Pushed result already consumed by forwarding |
| wb_data | input | 32 | Result value |
| vars_ld | input | 1 | Load the locals base |
| vars_val | input | 5 | New locals base |
| rd0_data | output | 32 | Read port 0 data |
| rd1_data | output | 32 | Read port 1 data |
| sp | output | 6 | Stack pointer (occupied entries, 0..32) |
| vars | output | 5 | Locals base |
| fault | output | 1 | Stack pointer range violation in the previous cycle |

## Verification
The hardest state to observe is a suppressed write. A forwarded-and-consumed push leaves a stale entry that no later instruction would normally read. The stimulus first fills that slot with a known value and pops it away. It then pushes a different value with the forward mark set and, in the next idle cycle, reads the top of stack through a read port, where the old value must still appear. The overflow case needs 32 pushes with no fault before the 33rd push, so the bench drives a long fill run and then one extra push.

// File: rtl/sl_pkg.sv
// Shared types for the stack and locals register bank.
package sl_pkg;
    // Base selection for a read port or the write-back target.
    typedef enum logic {
        BASE_STACK  = 1'b0,
        BASE_LOCALS = 1'b1
    } base_e;
endpackage

// File: rtl/sl_ptr_unit.sv
// Pointer unit: holds the stack pointer and the locals base, applies
// the net push/pop step of the write-back instruction and refuses a
// step that leaves 0..DEPTH. Assumes at most one instruction per cycle.
module sl_ptr_unit #(
    parameter int DEPTH = 32,
    parameter int POP_W = 2,
    localparam int A_W  = $clog2(DEPTH),
    localparam int SP_W = A_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_en,
    input  logic             wb_push,
    input  logic [POP_W-1:0] wb_pop,
    input  logic             vars_ld,
    input  logic [A_W-1:0]   vars_val,
    output logic [SP_W-1:0]  sp_q,
    output logic [A_W-1:0]   sp_lo,
    output logic [A_W-1:0]   vars_q,
    output logic             step_ok,
    output logic             fault_q
);
    logic [SP_W:0]   with_push;
    logic [SP_W:0]   stepped;
    logic            too_low;
    logic            too_high;
    logic            bad;
    logic [SP_W-1:0] sp_eff;

    // Compute the candidate pointer and its range check.
    always_comb begin
        with_push = {1'b0, sp_q} + (SP_W+1)'(wb_push);
        too_low   = with_push < (SP_W+1)'(wb_pop);
        stepped   = with_push - (SP_W+1)'(wb_pop);
        too_high  = stepped > (SP_W+1)'(DEPTH);
        bad       = wb_en & (too_low | too_high);
        step_ok   = wb_en & ~bad;
        sp_eff    = step_ok ? stepped[SP_W-1:0] : sp_q;
        sp_lo     = sp_eff[A_W-1:0];
    end

    // Register the pointers and the one-cycle fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            vars_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            sp_q    <= sp_eff;
            fault_q <= bad;
            if (vars_ld) vars_q <= vars_val;
        end
    end

    a_r2_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |=> (sp_q == $past(sp_q) + SP_W'($past(wb_push)) - SP_W'($past(wb_pop))));
    a_r3_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !step_ok) |=> (fault_q && sp_q == $past(sp_q)));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_W'(DEPTH));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> (sp_q == $past(sp_q) && !fault_q));
    a_r10_vars_load: assert property (@(posedge clk) disable iff (!rst_n)
        vars_ld |=> (vars_q == $past(vars_val)));
endmodule

// File: rtl/sl_array.sv
// Storage array: DEPTH words, one write port, NRD combinational read
// ports. Cleared by reset. Assumes the write address is already final.
module sl_array #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int NRD    = 2,
    localparam int A_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [A_W-1:0]    waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [A_W-1:0]    raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the write-back word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read every port straight from the array.
    always_comb begin
        for (int i = 0; i < NRD; i++) rdata[i] = mem[raddr[i]];
    end

    a_r6_r7_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sl_read_port.sv
// One operand-fetch port: forms the entry address from the chosen base
// and offset, and bypasses the in-flight write-back value on a match.
module sl_read_port
    import sl_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int A_W   = $clog2(DEPTH)
) (
    input  base_e             base,
    input  logic [A_W-1:0]    off,
    input  logic [A_W-1:0]    sp_lo,
    input  logic [A_W-1:0]    vars_q,
    input  logic              produced,
    input  logic [A_W-1:0]    waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_data,
    output logic [A_W-1:0]    addr,
    output logic [DATA_W-1:0] data
);
    // Address relative to the top of stack or to the locals base.
    always_comb begin
        if (base == BASE_STACK) addr = sp_lo - A_W'(1) - off;
        else                    addr = vars_q + off;
    end

    // Forward the result being written back when it hits this entry.
    always_comb begin
        data = (produced && waddr == addr) ? wdata : arr_data;
    end
endmodule

// File: rtl/sl_bank.sv
// Stack and locals register bank: one array shared by the operand stack
// and the local variable pool, two read ports, one write-back port with
// forwarding and write suppression for consumed results.
// Assumes one retiring instruction per cycle with at most one push.
module sl_bank
    import sl_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int POP_W  = 2,
    localparam int A_W   = $clog2(DEPTH),
    localparam int SP_W  = A_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd0_base,
    input  logic [A_W-1:0]    rd0_off,
    input  logic              rd1_base,
    input  logic [A_W-1:0]    rd1_off,
    input  logic              wb_en,
    input  logic              wb_dst,
    input  logic [A_W-1:0]    wb_idx,
    input  logic              wb_push,
    input  logic [POP_W-1:0]  wb_pop,
    input  logic              wb_fwd,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              vars_ld,
    input  logic [A_W-1:0]    vars_val,
    output logic [DATA_W-1:0] rd0_data,
    output logic [DATA_W-1:0] rd1_data,
    output logic [SP_W-1:0]   sp,
    output logic [A_W-1:0]    vars,
    output logic              fault
);
    localparam int NRD = 2;

    logic [A_W-1:0]    sp_lo;
    logic              step_ok;
    logic              produced;
    logic              store;
    logic [A_W-1:0]    waddr;
    logic [A_W-1:0]    rd_addr [NRD];
    logic [DATA_W-1:0] arr_q   [NRD];
    logic [DATA_W-1:0] rd_q    [NRD];
    base_e             rd_base [NRD];
    logic [A_W-1:0]    rd_off  [NRD];

    sl_ptr_unit #(.DEPTH(DEPTH), .POP_W(POP_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_push(wb_push),
        .wb_pop(wb_pop), .vars_ld(vars_ld), .vars_val(vars_val),
        .sp_q(sp), .sp_lo(sp_lo), .vars_q(vars), .step_ok(step_ok),
        .fault_q(fault)
    );

    // Decide whether a value is produced, where it goes and if it is kept.
    always_comb begin
        produced = step_ok & ((wb_dst == BASE_LOCALS) | wb_push);
        waddr    = (wb_dst == BASE_LOCALS) ? (vars + wb_idx) : (sp_lo - A_W'(1));
        store    = produced & ~((wb_dst == BASE_STACK) & wb_fwd);
    end

    // Gather the port controls into arrays for the generated ports.
    always_comb begin
        rd_base[0] = base_e'(rd0_base);
        rd_base[1] = base_e'(rd1_base);
        rd_off[0]  = rd0_off;
        rd_off[1]  = rd1_off;
        rd0_data   = rd_q[0];
        rd1_data   = rd_q[1];
    end

    sl_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(store), .waddr(waddr),
        .wdata(wb_data), .raddr(rd_addr), .rdata(arr_q)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        sl_read_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_port (
            .base(rd_base[g]), .off(rd_off[g]), .sp_lo(sp_lo),
            .vars_q(vars), .produced(produced), .waddr(waddr),
            .wdata(wb_data), .arr_data(arr_q[g]), .addr(rd_addr[g]),
            .data(rd_q[g])
        );
    end

    a_r9_fwd_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_fwd && wb_dst == BASE_STACK) |-> !store);
    a_r3_fault_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !step_ok) |-> !store);
endmodule

// File: tb/sl_bank_test.sv
// Bench: behavioural reference model compared every cycle.
module sl_bank_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rd0_base = 0, rd1_base = 0;
    logic [4:0]  rd0_off = 0, rd1_off = 0;
    logic        wb_en = 0, wb_dst = 0, wb_push = 0, wb_fwd = 0;
    logic [4:0]  wb_idx = 0;
    logic [1:0]  wb_pop = 0;
    logic [31:0] wb_data = 0;
    logic        vars_ld = 0;
    logic [4:0]  vars_val = 0;
    logic [31:0] rd0_data, rd1_data;
    logic [5:0]  sp;
    logic [4:0]  vars;
    logic        fault;

    sl_bank uut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model
    int m_mem [32];
    int m_sp = 0, m_vars = 0;
    bit m_fault = 0;

    // next-cycle stimulus, applied at the falling edge
    bit n_rb0, n_rb1, n_en, n_dst, n_push, n_fwd, n_vld;
    int n_ro0, n_ro1, n_idx, n_pop, n_vval;
    int unsigned n_data;

    function automatic bit m_bad();
        int t = m_sp + n_push - n_pop;
        return n_en && (t < 0 || t > 32);
    endfunction

    function automatic int m_sp_eff();
        return (n_en && !m_bad()) ? m_sp + n_push - n_pop : m_sp;
    endfunction

    function automatic bit m_prod();
        return n_en && !m_bad() && (n_dst || n_push);
    endfunction

    function automatic int m_waddr();
        return n_dst ? ((m_vars + n_idx) & 31) : ((m_sp_eff() - 1) & 31);
    endfunction

    function automatic int unsigned m_read(bit base, int off);
        int a = base ? ((m_vars + off) & 31) : ((m_sp_eff() - 1 - off) & 31);
        if (m_prod() && a == m_waddr()) return n_data;
        return m_mem[a];
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        n_en = 0; n_dst = 0; n_push = 0; n_pop = 0; n_fwd = 0; n_idx = 0;
        n_vld = 0; n_vval = 0; n_data = 0;
    endtask

    task automatic step(string tag);
        @(negedge clk);
        rd0_base = n_rb0; rd0_off = 5'(n_ro0);
        rd1_base = n_rb1; rd1_off = 5'(n_ro1);
        wb_en = n_en; wb_dst = n_dst; wb_idx = 5'(n_idx); wb_push = n_push;
        wb_pop = 2'(n_pop); wb_fwd = n_fwd; wb_data = n_data;
        vars_ld = n_vld; vars_val = 5'(n_vval);
        #5;
        chk(tag, "sp", sp, m_sp);
        chk(tag, "vars", vars, m_vars);
        chk(tag, "fault", fault, m_fault);
        chk(tag, "rd0", rd0_data, m_read(n_rb0, n_ro0));
        chk(tag, "rd1", rd1_data, m_read(n_rb1, n_ro1));
        @(posedge clk);
        begin
            bit bad = m_bad();
            int se = m_sp_eff();
            if (m_prod() && !(!n_dst && n_fwd)) m_mem[m_waddr()] = n_data;
            m_sp = se;
            m_fault = bad;
            if (n_vld) m_vars = n_vval;
        end
    endtask

    task automatic push(string tag, int unsigned v, bit fwd);
        idle(); n_en = 1; n_push = 1; n_data = v; n_fwd = fwd; step(tag);
    endtask

    task automatic pop(string tag, int cnt);
        idle(); n_en = 1; n_pop = cnt; step(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 0;
        n_rb0 = 0; n_rb1 = 1; n_ro0 = 0; n_ro1 = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state, locals read of entry 0 and stack read
        step("R1"); n_ro1 = 7; step("R1");

        // R2 R6 R8: pushes, port0 top forwarded in the push cycle
        n_rb0 = 0; n_ro0 = 0; n_rb1 = 0; n_ro1 = 1;
        for (int i = 0; i < 5; i++) push("R2 R6 R8", 32'h100 + i, 0);
        // R4 R11: idle reads at several depths
        idle(); n_ro0 = 2; n_ro1 = 4; step("R4 R11"); step("R4 R11");
        n_ro0 = 0; n_ro1 = 3; step("R4 R11");

        // R10: load locals base, same-cycle locals read uses old base
        idle(); n_vld = 1; n_vval = 16; n_rb1 = 1; n_ro1 = 0; step("R10");
        idle(); step("R10");
        // R7 R5 R2: local stores popping the stack, locals reads
        n_rb0 = 1; n_ro0 = 0; n_rb1 = 1; n_ro1 = 1;
        for (int i = 0; i < 3; i++) begin
            idle(); n_en = 1; n_dst = 1; n_idx = i; n_pop = 1;
            n_data = 32'hA000 + i; n_ro0 = i; step("R7 R8 R2");
        end
        idle(); n_ro0 = 2; n_ro1 = 0; step("R5");
        // R5: wrap of locals address
        idle(); n_vld = 1; n_vval = 30; step("R5 R10");
        idle(); n_ro0 = 5; n_ro1 = 1; step("R5");

        // R9: consumed push is not stored
        n_rb0 = 0; n_ro0 = 0; n_rb1 = 0; n_ro1 = 0;
        push("R9", 32'h5555, 0);
        pop("R9", 1);
        push("R9", 32'h7777, 1);
        idle(); step("R9");
        pop("R9", 1);

        // R3: underflow from a short stack
        idle(); step("R3");
        pop("R3", 3); idle(); step("R3"); step("R3");
        while (m_sp > 0) pop("R3", (m_sp >= 2) ? 2 : 1);
        pop("R3", 1); idle(); step("R3");
        // R3: overflow after a full stack
        for (int i = 0; i < 32; i++) push("R2 R6", 32'h900 + i, 0);
        push("R3", 32'hDEAD, 0);
        idle(); n_ro1 = 31; step("R3"); step("R3");
        // R3: local store with an illegal pop is also refused
        while (m_sp > 1) pop("R2", 2);
        idle(); n_en = 1; n_dst = 1; n_idx = 4; n_pop = 3; n_data = 32'hBAD;
        n_rb1 = 1; n_ro1 = 4; step("R3 R7");
        idle(); step("R3 R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule